// File: doc/BRIEF.md
# Armed-Flag Interrupt Controller

This block gathers per-device attention flags, a software-loaded arm mask and a global enable bit, and asserts one interrupt request towards the CPU. The request is active while the enable bit is set and at least one flag is both set and armed. Devices raise and drop their flag bits with single-cycle set and clear pulses. The CPU reaches the block through its I/O-transfer instructions. It presents the instruction word with a strobe and the accumulator value. It signals the end of every instruction and acknowledges an interrupt when it takes one.

Four instructions are decoded. The first ORs the flag register into the accumulator path. The second loads the arm mask from the accumulator. The third turns the enable bit off at once. The fourth turns it on only after one more instruction has completed, so a return sequence can finish before a new interrupt is taken. Taking an interrupt clears the enable bit, and software must turn it back on.

Top module: `irq_arm_ctrl`

## Requirements
- R1: After reset the arm mask is all ones, the flag register holds FLAG_RST (default 16'h0003: bit 0 is the frame-sync flag, bit 1 the transmitter-ready flag), the enable bit is clear and no enable is pending.
- R2: irq_o is high exactly when the enable bit is set and (flags & arm mask) is non-zero.
- R3: An instruction is decoded only when insn_vld_i is high and insn_i[15:9] equals 7'o001. A read-flags instruction (insn_i[8:0] & 9'o771 == 9'o101) makes ac_o equal ac_i OR flags in the same cycle. Otherwise ac_o equals ac_i.
- R4: A load-arm instruction (insn_i[8:0] & 9'o771 == 9'o141) loads the arm mask from ac_i at the next clock edge.
- R5: A disable instruction (insn_i[8:0] & 9'o771 == 9'o161) clears the enable bit at the next clock edge and cancels any pending enable.
- R6: An enable instruction (insn_i[8:0] & 9'o772 == 9'o162) arms a countdown of DELAY_STEPS (default 2) insn_done_i pulses. The enable bit is set at the edge that ends the cycle of the last of these pulses. The first pulse is the completion of the enable instruction itself.
- R7: ack_i clears the enable bit at the next edge, and it overrides a countdown expiring in the same cycle.
- R8: flag_set_i[n] sets flag n and flag_clr_i[n] clears it at the next edge. When both are high in the same cycle, the flag is set.
- R9: An instruction word with insn_vld_i low, with a class field other than 7'o001, or with an undecoded low field changes neither flags, arm mask, enable nor ac_o.
- R10: A word that matches both the disable and the enable pattern (low field 9'o163) clears the enable bit at once and starts a fresh countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_set_i | input | 16 | Per-flag set pulses |
| flag_clr_i | input | 16 | Per-flag clear pulses |
| insn_i | input | 16 | Instruction word |
| insn_vld_i | input | 1 | Instruction strobe |
| ac_i | input | 16 | Accumulator value from the CPU |
| ac_o | output | 16 | Accumulator value returned to the CPU |
| insn_done_i | input | 1 | Instruction-completed pulse |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
The request function is tried with the arm mask at zero and at single-bit values, with flags set and cleared under a fixed mask, and with the enable bit toggled by each route: delayed enable, disable, acknowledge and the combined word. Together these separate a wrong AND/OR reduction from a wrong enable path. The delayed enable is sampled after the strobe, after one completion and after two, which exposes an off-by-one in the countdown. A disable placed inside the countdown shows whether the pending enable is really cancelled. Words that differ from a decoded pattern only in the strobe, the class field or the device field prove that the decode is exact.

// File: rtl/irq_arm_pkg.sv
package irq_arm_pkg;
  localparam int INSN_W = 16;
  localparam logic [6:0] IOT_CLASS = 7'o001;
  localparam logic [8:0] MASK_A    = 9'o771;
  localparam logic [8:0] MASK_B    = 9'o772;
  localparam logic [8:0] OP_RDFLAG = 9'o101;
  localparam logic [8:0] OP_LDARM  = 9'o141;
  localparam logic [8:0] OP_IEOFF  = 9'o161;
  localparam logic [8:0] OP_IEON   = 9'o162;

  typedef struct packed {
    logic rd_flags;
    logic ld_arm;
    logic ie_off;
    logic ie_on;
  } iot_cmd_t;
endpackage

// File: rtl/irq_iot_dec.sv
module irq_iot_dec
  import irq_arm_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_vld_i,
  output iot_cmd_t          cmd_o
);
  logic hit;
  assign hit = insn_vld_i && (insn_i[15:9] == IOT_CLASS);

  always_comb begin
    cmd_o.rd_flags = hit && ((insn_i[8:0] & MASK_A) == OP_RDFLAG);
    cmd_o.ld_arm   = hit && ((insn_i[8:0] & MASK_A) == OP_LDARM);
    cmd_o.ie_off   = hit && ((insn_i[8:0] & MASK_A) == OP_IEOFF);
    cmd_o.ie_on    = hit && ((insn_i[8:0] & MASK_B) == OP_IEON);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int           W        = 16,
  parameter logic [W-1:0] FLAG_RST = 16'h0003,
  parameter logic [W-1:0] ARM_RST  = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         arm_we_i,
  input  logic [W-1:0] arm_din_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] arm_o
);
  logic [W-1:0] flags_q, arm_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_q[i] <= FLAG_RST[i];
      else if (set_i[i])   flags_q[i] <= 1'b1;  // set wins over clear
      else if (clr_i[i])   flags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       arm_q <= ARM_RST;
    else if (arm_we_i) arm_q <= arm_din_i;
  end

  assign flags_o = flags_q;
  assign arm_o   = arm_q;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  a_r8_clr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
  a_r4_arm_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_we_i |=> (arm_q == $past(arm_din_i)));
  a_r9_arm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_we_i |=> $stable(arm_q));
endmodule

// File: rtl/irq_enable_seq.sv
module irq_enable_seq #(
  parameter int DELAY_STEPS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic done_i,
  input  logic ack_i,
  output logic ie_o
);
  localparam int CW = $clog2(DELAY_STEPS + 1);
  localparam logic [CW-1:0] LOAD_FULL = CW'(DELAY_STEPS);
  localparam logic [CW-1:0] LOAD_LESS = CW'(DELAY_STEPS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ie_q, ie_d, expire;

  assign expire = !on_i && !off_i && done_i && (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (on_i)                       cnt_d = done_i ? LOAD_LESS : LOAD_FULL;
    else if (off_i)                 cnt_d = '0;
    else if (done_i && cnt_q != '0) cnt_d = cnt_q - CW'(1);

    ie_d = ie_q;
    if (expire)         ie_d = 1'b1;
    if (off_i || ack_i) ie_d = 1'b0;  // clear has priority
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ie_q  <= ie_d;
    end
  end

  assign ie_o = ie_q;

  a_r5_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> !ie_q);
  a_r5_off_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i && !on_i) |=> (cnt_q == '0));
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ie_q);
  a_r6_rise_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ie_q) |-> ($past(done_i) && !$past(on_i)));
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl
  import irq_arm_pkg::*;
#(
  parameter int              W           = 16,
  parameter logic [W-1:0]    FLAG_RST    = 16'h0003,
  parameter int              DELAY_STEPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      flag_set_i,
  input  logic [W-1:0]      flag_clr_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_vld_i,
  input  logic [W-1:0]      ac_i,
  output logic [W-1:0]      ac_o,
  input  logic              insn_done_i,
  input  logic              ack_i,
  output logic              irq_o
);
  iot_cmd_t     cmd;
  logic [W-1:0] flags, arm;
  logic         ie;

  irq_iot_dec u_dec (
    .insn_i     (insn_i),
    .insn_vld_i (insn_vld_i),
    .cmd_o      (cmd)
  );

  irq_flag_bank #(.W(W), .FLAG_RST(FLAG_RST), .ARM_RST('1)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flag_set_i),
    .clr_i     (flag_clr_i),
    .arm_we_i  (cmd.ld_arm),
    .arm_din_i (ac_i),
    .flags_o   (flags),
    .arm_o     (arm)
  );

  irq_enable_seq #(.DELAY_STEPS(DELAY_STEPS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .on_i   (cmd.ie_on),
    .off_i  (cmd.ie_off),
    .done_i (insn_done_i),
    .ack_i  (ack_i),
    .ie_o   (ie)
  );

  assign ac_o  = cmd.rd_flags ? (ac_i | flags) : ac_i;
  assign irq_o = ie && (|(flags & arm));

  a_r2_irq_drops_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
  a_r3_ac_superset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ac_o & ac_i) == ac_i));
endmodule

// File: tb/tb_irq_arm_ctrl.sv
module tb_irq_arm_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] flag_set_i = '0, flag_clr_i = '0, insn_i = '0, ac_i = '0;
  logic        insn_vld_i = 1'b0, insn_done_i = 1'b0, ack_i = 1'b0;
  logic [15:0] ac_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  localparam logic [15:0] I_RD  = 16'o001101;
  localparam logic [15:0] I_ARM = 16'o001141;
  localparam logic [15:0] I_OFF = 16'o001161;
  localparam logic [15:0] I_ON  = 16'o001162;
  localparam logic [15:0] I_BTH = 16'o001163;

  always #2 clk_i = ~clk_i;

  irq_arm_ctrl dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic iot(input logic [15:0] w, input logic [15:0] a, input logic v = 1'b1);
    insn_i = w; ac_i = a; insn_vld_i = v;
    step();
    insn_vld_i = 1'b0; insn_i = '0; ac_i = '0;
  endtask

  task automatic done(input logic with_ack = 1'b0);
    insn_done_i = 1'b1; ack_i = with_ack;
    step();
    insn_done_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic read_flags(input logic [15:0] a, output logic [15:0] r);
    insn_i = I_RD; ac_i = a; insn_vld_i = 1'b1;
    #1 r = ac_o;
    step();
    insn_vld_i = 1'b0; insn_i = '0; ac_i = '0;
  endtask

  task automatic pulse_flags(input logic [15:0] s, input logic [15:0] c);
    flag_set_i = s; flag_clr_i = c;
    step();
    flag_set_i = '0; flag_clr_i = '0;
  endtask

  task automatic enable_ie();
    iot(I_ON, '0); done(); done();
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1 irq low after reset", 16'(irq_o), 16'h0);
    read_flags(16'h0000, r);
    chk("R1/R3 reset flags", r, 16'h0003);
    ac_i = 16'h1234; #1;
    chk("R3 ac passes when idle", ac_o, 16'h1234);
    ac_i = '0;
  endtask

  task automatic t_ion_delay();
    iot(I_ON, '0);
    chk("R6 not on after strobe", 16'(irq_o), 16'h0);
    done();
    chk("R6 not on after first done", 16'(irq_o), 16'h0);
    done();
    chk("R6/R1 on after second done with reset arm", 16'(irq_o), 16'h1);
  endtask

  task automatic t_arm();
    iot(I_ARM, 16'h0000);
    chk("R4 arm zero masks irq", 16'(irq_o), 16'h0);
    iot(I_ARM, 16'h0002);
    chk("R2 armed bit1 raises irq", 16'(irq_o), 16'h1);
    pulse_flags(16'h0000, 16'h0002);
    chk("R2 cleared flag drops irq", 16'(irq_o), 16'h0);
    pulse_flags(16'h0020, 16'h0000);
    chk("R2 unarmed flag no irq", 16'(irq_o), 16'h0);
    iot(I_ARM, 16'h0020);
    chk("R4 arm bit5 raises irq", 16'(irq_o), 16'h1);
  endtask

  task automatic t_flags();
    logic [15:0] r;
    pulse_flags(16'h0080, 16'h0080);
    read_flags(16'h0000, r);
    chk("R8 set wins over clear", r, 16'h00A1);
    pulse_flags(16'h0000, 16'h0080);
    read_flags(16'h0000, r);
    chk("R8 clear alone", r, 16'h0021);
    read_flags(16'h8000, r);
    chk("R3 flags ORed into ac", r, 16'h8021);
  endtask

  task automatic t_ignore();
    iot(I_ARM, 16'h0000, 1'b0);
    chk("R9 no strobe no arm load", 16'(irq_o), 16'h1);
    iot(16'o001151, 16'h0000);
    chk("R9 wrong device no arm load", 16'(irq_o), 16'h1);
    iot(16'o003141, 16'h0000);
    chk("R9 wrong class no arm load", 16'(irq_o), 16'h1);
    insn_i = 16'o001111; ac_i = 16'h0000; insn_vld_i = 1'b1; #1;
    chk("R9 undecoded read leaves ac", ac_o, 16'h0000);
    step(); insn_vld_i = 1'b0; insn_i = '0;
    chk("R9 undecoded word keeps enable", 16'(irq_o), 16'h1);
  endtask

  task automatic t_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
    chk("R7 ack clears enable", 16'(irq_o), 16'h0);
  endtask

  task automatic t_iof();
    enable_ie();
    chk("R6 re-enabled", 16'(irq_o), 16'h1);
    iot(I_OFF, '0);
    chk("R5 disable clears at once", 16'(irq_o), 16'h0);
    iot(I_ON, '0); done();
    iot(I_OFF, '0); done(); done();
    chk("R5 disable cancels pending enable", 16'(irq_o), 16'h0);
  endtask

  task automatic t_ack_expiry();
    iot(I_ON, '0); done(); done(1'b1);
    chk("R7 ack beats expiry", 16'(irq_o), 16'h0);
    done();
    chk("R7 no late enable after ack", 16'(irq_o), 16'h0);
  endtask

  task automatic t_both();
    enable_ie();
    chk("R10 precondition enabled", 16'(irq_o), 16'h1);
    iot(I_BTH, '0);
    chk("R10 combined word clears", 16'(irq_o), 16'h0);
    done();
    chk("R10 still off after one done", 16'(irq_o), 16'h0);
    done();
    chk("R10 on after fresh countdown", 16'(irq_o), 16'h1);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_ion_delay();
    t_arm();
    t_flags();
    t_ignore();
    t_ack();
    t_iof();
    t_ack_expiry();
    t_both();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule